// File: doc/BRIEF.md
# Multi-Queue Shared-Memory FIFO Manager

This block keeps 64 independent word FIFOs inside one shared single-clock SRAM of 128 pages, each page 16 words deep. Each queue is described by a 32-bit configuration word. The word gives the queue's capacity, its first page in the shared memory, and two 3-bit watermark codes. For every queue the block keeps a read pointer, a write pointer and a fill count. From these it derives empty, nearly-empty, nearly-full and full flags, and for the lower half of the queues a sticky overflow flag.

Software reaches the block through two independent channels. The write channel pushes a data word, writes a configuration word, or clears overflow flags. The read channel pops a data word, reads back a configuration word, or reads one of the packed status words. Both channels may be active in the same cycle, so a push and a pop can hit the same queue together. Every read answers exactly one cycle later on `rd_data`, qualified by `rd_valid`. A status or configuration read shows the state as it was before the operations of its own cycle.

An address is `{region[1:0], index[5:0]}`. Region 0 is queue data, with the index naming the queue. Region 1 is the configuration word of the indexed queue. Region 2 is status, with the index naming a status word. Region 3 reads as zero and ignores writes.

Top module: `qm_fifo_mgr`

## Requirements
- R1: After reset every configuration word is zero. Status words 0 to 3 read 0x33333333, status words 4 and 5 read zero, status word 6 reads 0xFFFFFFFF and status word 7 reads zero.
- R2: The configuration word fields are as follows. Bits 25:24 are the size code, where 0, 1, 2 and 3 mean 16, 32, 64 and 128 words. Bits 21:14 are the base in 16-word pages, and a base of zero marks the queue unconfigured. Bits 28:26 are the nearly-empty code and bits 31:29 the nearly-full code. A configuration read returns the last word written, and writing the word leaves the queue empty.
- R3: Words popped from a queue come out in the order they were pushed. Pop data appears on `rd_data` with `rd_valid` high in the cycle after `rd_en`.
- R4: A pop from an empty queue returns zero and moves no pointer. The next word pushed is the next word popped.
- R5: A push into a full queue is dropped and the fill count is kept. For queues 0 to 31 the push sets the overflow flag, which stays set until a status write to word 4 + q/16 carries a 1 at bit (q mod 16)×2.
- R6: Status word q/8 (words 0 to 3) holds the 4-bit nibble of queue q (q below 32) at bit offset (q mod 8)×4. In the nibble, bit 0 is empty, bit 1 nearly-empty, bit 2 nearly-full and bit 3 full.
- R7: Watermark code n sets a threshold of 0 when n is 0 and 2^(n−1) words otherwise. Nearly-empty holds when the fill count is at or below its threshold. Nearly-full holds when the free space is at or below its threshold.
- R8: For queues 32 to 63, status word 6 bit q−32 is nearly-empty and status word 7 bit q−32 is full.
- R9: A push and a pop to the same queue in one cycle both take effect when the queue is neither empty nor full, and the fill count does not change.
- R10: A push to an unconfigured queue is ignored. The queue stays empty and no overflow flag is set.
- R11: Status word 4 + q/16 (words 4 and 5) holds the overflow flag of queue q (q below 32) at bit (q mod 16)×2, and the odd bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write-channel request |
| wr_addr | input | 8 | Write address `{region, index}` |
| wr_data | input | 32 | Push data, configuration word or overflow clear mask |
| rd_en | input | 1 | Read-channel request |
| rd_addr | input | 8 | Read address `{region, index}` |
| rd_valid | output | 1 | High in the cycle after a read request |
| rd_data | output | 32 | Pop data, configuration word or status word |

## Verification
A wrong fill count shows up in the packed flags at the next status read of that queue. It also shows as a spurious zero or a stale word at the next pop, and both become visible one cycle after the request. A bad read or write pointer changes the popped word sequence on the first pop after the fault, so data order is checked on every pop. A lost or stuck overflow flag appears in status word 4 or 5 on the read that follows the full push or the clear. Directed cases cover the exact boundaries of each watermark, and a long random mix of pushes, pops, reconfigurations and clears across several queues keeps a reference model in step with every read.

// File: rtl/qm_pkg.sv
package qm_pkg;

  localparam int unsigned QM_WORD_W = 32;

  typedef enum logic [1:0] {
    RG_DATA = 2'd0,
    RG_CFG  = 2'd1,
    RG_STAT = 2'd2,
    RG_NONE = 2'd3
  } region_e;

  // field positions are decoded by software, keep them fixed
  typedef struct packed {
    logic [2:0]  nf_code;    // 31:29
    logic [2:0]  ne_code;    // 28:26
    logic [1:0]  size_code;  // 25:24
    logic [1:0]  spare;      // 23:22
    logic [7:0]  base;       // 21:14
    logic [13:0] low;        // 13:0
  } qcfg_t;

  function automatic logic [7:0] wm_thresh(input logic [2:0] code);
    return (code == 3'd0) ? 8'd0 : (8'd1 << (code - 3'd1));
  endfunction

endpackage

// File: rtl/qm_sram.sv
module qm_sram #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/qm_flags.sv
module qm_flags
  import qm_pkg::*;
#(
  parameter int unsigned PAGE_WORDS = 16,
  parameter int unsigned CNT_W      = 8
) (
  input  logic [CNT_W-1:0] count,
  input  logic [1:0]       size_code,
  input  logic [2:0]       ne_code,
  input  logic [2:0]       nf_code,
  output logic [3:0]       flags   // {full, nearly full, nearly empty, empty}
);
  logic [CNT_W-1:0] cap, room, ne_thr, nf_thr;

  always_comb begin
    cap      = CNT_W'(PAGE_WORDS) << size_code;
    room     = cap - count;
    ne_thr   = CNT_W'(wm_thresh(ne_code));
    nf_thr   = CNT_W'(wm_thresh(nf_code));
    flags[0] = (count == '0);
    flags[1] = (count <= ne_thr);
    flags[2] = (room <= nf_thr);
    flags[3] = (count == cap);
  end
endmodule

// File: rtl/qm_fifo_mgr.sv
module qm_fifo_mgr
  import qm_pkg::*;
#(
  parameter int unsigned QUEUES     = 64,
  parameter int unsigned PAGES      = 128,
  parameter int unsigned PAGE_WORDS = 16,
  localparam int unsigned QW        = $clog2(QUEUES),
  localparam int unsigned ADDR_W    = QW + 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [QM_WORD_W-1:0] wr_data,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic                 rd_valid,
  output logic [QM_WORD_W-1:0] rd_data
);
  localparam int unsigned HALF     = QUEUES / 2;
  localparam int unsigned MAXQ_W   = PAGE_WORDS << 3;
  localparam int unsigned PTR_W    = $clog2(MAXQ_W);
  localparam int unsigned CNT_W    = $clog2(MAXQ_W + 1);
  localparam int unsigned SRAM_D   = PAGES * PAGE_WORDS;
  localparam int unsigned SRAM_AW  = $clog2(SRAM_D);
  localparam int          PRI_N    = HALF / 8;
  localparam int          SEC_BASE = PRI_N;
  localparam int          NE_IDX   = PRI_N + ((HALF + 15) / 16);
  localparam int          FULL_IDX = NE_IDX + 1;

  region_e          wreg, rreg;
  logic [QW-1:0]    wq, rq;
  qcfg_t            cfg_a   [QUEUES];
  logic [PTR_W-1:0] rp_a    [QUEUES];
  logic [PTR_W-1:0] wp_a    [QUEUES];
  logic [3:0]       flags_a [QUEUES];
  logic [HALF-1:0]  ovf_v;

  logic push, pop, cfg_wr, stat_wr, push_ok, push_drop, pop_ok;
  logic [SRAM_AW-1:0]   sram_waddr, sram_raddr;
  logic [QM_WORD_W-1:0] sram_q, rsel, reg_q;
  logic                 pop_sel_q, pop_ok_q;

  assign wreg = region_e'(wr_addr[ADDR_W-1 -: 2]);
  assign rreg = region_e'(rd_addr[ADDR_W-1 -: 2]);
  assign wq   = wr_addr[QW-1:0];
  assign rq   = rd_addr[QW-1:0];

  always_comb begin
    push      = wr_en && (wreg == RG_DATA);
    cfg_wr    = wr_en && (wreg == RG_CFG);
    stat_wr   = wr_en && (wreg == RG_STAT);
    pop       = rd_en && (rreg == RG_DATA);
    push_ok   = push && (cfg_a[wq].base != '0) && !flags_a[wq][3];
    push_drop = push && (cfg_a[wq].base != '0) && flags_a[wq][3];
    pop_ok    = pop && !flags_a[rq][0];
  end

  assign sram_waddr = SRAM_AW'(32'(cfg_a[wq].base) * PAGE_WORDS + 32'(wp_a[wq]));
  assign sram_raddr = SRAM_AW'(32'(cfg_a[rq].base) * PAGE_WORDS + 32'(rp_a[rq]));

  qm_sram #(.WORD_W(QM_WORD_W), .DEPTH(SRAM_D)) u_sram (
    .clk(clk), .we(push_ok), .waddr(sram_waddr), .wdata(wr_data),
    .re(pop_ok), .raddr(sram_raddr), .rdata(sram_q)
  );

  for (genvar g = 0; g < QUEUES; g++) begin : g_q
    qcfg_t            cfg_r;
    logic [CNT_W-1:0] cnt_r;
    logic [PTR_W-1:0] rp_r, wp_r, wrap_m;
    logic             hit_w, hit_r, inc, dec;

    assign hit_w  = (wq == QW'(g));
    assign hit_r  = (rq == QW'(g));
    assign inc    = push_ok && hit_w;
    assign dec    = pop_ok && hit_r;
    assign wrap_m = PTR_W'((PAGE_WORDS << cfg_r.size_code) - 1);

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_r <= '0;
        cnt_r <= '0;
        rp_r  <= '0;
        wp_r  <= '0;
      end else if (cfg_wr && hit_w) begin
        cfg_r <= qcfg_t'(wr_data);
        cnt_r <= '0;
        rp_r  <= '0;
        wp_r  <= '0;
      end else begin
        if (inc) wp_r <= (wp_r + 1'b1) & wrap_m;
        if (dec) rp_r <= (rp_r + 1'b1) & wrap_m;
        if (inc != dec) cnt_r <= inc ? cnt_r + 1'b1 : cnt_r - 1'b1;
      end
    end

    assign cfg_a[g] = cfg_r;
    assign rp_a[g]  = rp_r;
    assign wp_a[g]  = wp_r;

    qm_flags #(.PAGE_WORDS(PAGE_WORDS), .CNT_W(CNT_W)) u_flags (
      .count(cnt_r), .size_code(cfg_r.size_code),
      .ne_code(cfg_r.ne_code), .nf_code(cfg_r.nf_code), .flags(flags_a[g])
    );

    if (g < HALF) begin : g_ovf
      logic ovf_r, clr;
      assign clr = stat_wr && (wq == QW'(SEC_BASE + g / 16)) && wr_data[(g % 16) * 2];
      always_ff @(posedge clk) begin
        if (rst)                     ovf_r <= 1'b0;
        else if (push_drop && hit_w) ovf_r <= 1'b1;
        else if (clr)                ovf_r <= 1'b0;
      end
      assign ovf_v[g] = ovf_r;
    end
  end

  always_comb begin
    rsel = '0;
    case (rreg)
      RG_CFG: rsel = cfg_a[rq];
      RG_STAT: begin
        for (int g = 0; g < HALF; g++) begin
          if (int'(rq) == g / 8)             rsel[(g % 8) * 4 +: 4] = flags_a[g];
          if (int'(rq) == SEC_BASE + g / 16) rsel[(g % 16) * 2]     = ovf_v[g];
        end
        for (int g = HALF; g < QUEUES; g++) begin
          if (int'(rq) == NE_IDX)   rsel[g - HALF] = flags_a[g][1];
          if (int'(rq) == FULL_IDX) rsel[g - HALF] = flags_a[g][3];
        end
      end
      default: rsel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid  <= 1'b0;
      pop_sel_q <= 1'b0;
      pop_ok_q  <= 1'b0;
      reg_q     <= '0;
    end else begin
      rd_valid  <= rd_en;
      pop_sel_q <= pop;
      pop_ok_q  <= pop_ok;
      reg_q     <= rsel;
    end
  end

  assign rd_data = !pop_sel_q ? reg_q : (pop_ok_q ? sram_q : '0);
endmodule

// File: rtl/qm_fifo_mgr_chk.sv
module qm_fifo_mgr_chk #(
  parameter int unsigned QUEUES = 64,
  localparam int unsigned QW     = $clog2(QUEUES),
  localparam int unsigned ADDR_W = QW + 2,
  localparam int unsigned HALF   = QUEUES / 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic [3:0]        flags_a [QUEUES],
  input logic [HALF-1:0]   ovf_v
);
  logic wdat, rdat, wcfg;
  assign wdat = wr_en && (wr_addr[ADDR_W-1 -: 2] == 2'd0);
  assign rdat = rd_en && (rd_addr[ADDR_W-1 -: 2] == 2'd0);
  assign wcfg = wr_en && (wr_addr[ADDR_W-1 -: 2] == 2'd1);

  // R4: popping an empty queue yields zero
  p_empty_pop_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (rdat && flags_a[rd_addr[QW-1:0]][0]) |=> (rd_data == '0));

  for (genvar g = 0; g < QUEUES; g++) begin : g_a
    // R1: queues leave reset empty and nearly empty
    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (flags_a[g] == 4'h3));

    // R2: a configuration write empties the queue
    p_cfg_empties_r2: assert property (@(posedge clk) disable iff (rst)
      (wcfg && wr_addr[QW-1:0] == QW'(g)) |=> (flags_a[g][0] && !flags_a[g][3]));

    // R5: a push into a full queue does not change its fill
    p_full_drop_r5: assert property (@(posedge clk) disable iff (rst)
      (wdat && wr_addr[QW-1:0] == QW'(g) && flags_a[g][3] &&
       !(rdat && rd_addr[QW-1:0] == QW'(g))) |=> flags_a[g][3]);

    // R9: push and pop together keep the fill of a mid-level queue
    p_push_pop_same_r9: assert property (@(posedge clk) disable iff (rst)
      (wdat && rdat && wr_addr[QW-1:0] == QW'(g) && rd_addr[QW-1:0] == QW'(g) &&
       !flags_a[g][0] && !flags_a[g][3]) |=> $stable(flags_a[g]));

    if (g < HALF) begin : g_o
      // R5: a dropped push raises the sticky overflow flag
      p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        (wdat && wr_addr[QW-1:0] == QW'(g) && flags_a[g][3]) |=> ovf_v[g]);
    end
  end
endmodule

bind qm_fifo_mgr qm_fifo_mgr_chk #(.QUEUES(QUEUES)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .rd_en(rd_en),
  .rd_addr(rd_addr), .rd_data(rd_data), .flags_a(flags_a), .ovf_v(ovf_v)
);

// File: tb/test_qm_fifo_mgr.sv
module test_qm_fifo_mgr;
  localparam int Q = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_valid;
  logic [31:0] rd_data;

  int n_checks = 0, n_err = 0;

  logic [31:0] m_cfg [Q];
  int          m_cnt [Q], m_rp [Q], m_wp [Q];
  logic [31:0] m_mem [Q][128];
  bit          m_ovf [32];
  logic [31:0] last_rd;

  qm_fifo_mgr i_qm_fifo_mgr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  function automatic int cap(int q);
    return 16 << m_cfg[q][25:24];
  endfunction

  function automatic int thr(logic [2:0] c);
    return (c == 0) ? 0 : (1 << (c - 1));
  endfunction

  function automatic logic [3:0] exp_flags(int q);
    int c = m_cnt[q];
    int k = cap(q);
    return {c == k, (k - c) <= thr(m_cfg[q][31:29]), c <= thr(m_cfg[q][28:26]), c == 0};
  endfunction

  function automatic logic [31:0] exp_stat(int idx);
    logic [31:0] w = '0;
    logic [3:0]  f;
    if (idx < 4) begin
      for (int k = 0; k < 8; k++) w[k*4 +: 4] = exp_flags(idx*8 + k);
    end else if (idx < 6) begin
      for (int k = 0; k < 16; k++) w[k*2] = m_ovf[(idx-4)*16 + k];
    end else if (idx < 8) begin
      for (int k = 0; k < 32; k++) begin
        f = exp_flags(32 + k);
        w[k] = (idx == 6) ? f[1] : f[3];
      end
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [7:0] wa, input logic [31:0] wd,
                     input bit re, input logic [7:0] ra, input string tag);
    logic [31:0] exp;
    int wq, rq;
    bit pop_ok, push_ok, drop, cfgw;
    wq = int'(wa[5:0]);
    rq = int'(ra[5:0]);
    wr_en = we; wr_addr = wa; wr_data = wd; rd_en = re; rd_addr = ra;
    exp = '0;
    if (re) begin
      case (ra[7:6])
        2'd0: exp = (m_cnt[rq] > 0) ? m_mem[rq][m_rp[rq]] : '0;
        2'd1: exp = m_cfg[rq];
        2'd2: exp = exp_stat(rq);
        default: exp = '0;
      endcase
    end
    pop_ok  = re && ra[7:6] == 2'd0 && m_cnt[rq] > 0;
    cfgw    = we && wa[7:6] == 2'd1;
    push_ok = we && wa[7:6] == 2'd0 && m_cfg[wq][21:14] != 0 && m_cnt[wq] < cap(wq);
    drop    = we && wa[7:6] == 2'd0 && m_cfg[wq][21:14] != 0 && m_cnt[wq] == cap(wq);
    @(posedge clk);
    if (pop_ok && !(cfgw && wq == rq)) begin
      m_rp[rq] = (m_rp[rq] + 1) % cap(rq);
      m_cnt[rq]--;
    end
    if (push_ok) begin
      m_mem[wq][m_wp[wq]] = wd;
      m_wp[wq] = (m_wp[wq] + 1) % cap(wq);
      m_cnt[wq]++;
    end
    if (drop && wq < 32) m_ovf[wq] = 1'b1;
    if (we && wa[7:6] == 2'd2 && (wq == 4 || wq == 5))
      for (int k = 0; k < 16; k++) if (wd[2*k]) m_ovf[(wq-4)*16 + k] = 1'b0;
    if (cfgw) begin
      m_cfg[wq] = wd; m_cnt[wq] = 0; m_rp[wq] = 0; m_wp[wq] = 0;
    end
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    if (re) begin
      last_rd = rd_data;
      check(rd_valid === 1'b1 && rd_data === exp, tag, rd_data, exp);
    end
  endtask

  task automatic push(input int q, input logic [31:0] d, input string tag);
    cyc(1'b1, {2'd0, 6'(q)}, d, 1'b0, 8'h0, tag);
  endtask
  task automatic pop(input int q, input string tag);
    cyc(1'b0, 8'h0, 32'h0, 1'b1, {2'd0, 6'(q)}, tag);
  endtask
  task automatic rstat(input int idx, input string tag);
    cyc(1'b0, 8'h0, 32'h0, 1'b1, {2'd2, 6'(idx)}, tag);
  endtask
  task automatic wcfg(input int q, input logic [31:0] v);
    cyc(1'b1, {2'd1, 6'(q)}, v, 1'b0, 8'h0, "R2");
  endtask
  function automatic logic [31:0] mkcfg(int nf, int ne, int sz, int base);
    return {3'(nf), 3'(ne), 2'(sz), 2'b00, 8'(base), 14'h0};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    int qs[8] = '{1, 2, 7, 12, 33, 45, 50, 63};
    void'($urandom(32'd24681));
    for (int q = 0; q < Q; q++) begin
      m_cfg[q] = '0; m_cnt[q] = 0; m_rp[q] = 0; m_wp[q] = 0;
    end
    for (int q = 0; q < 32; q++) m_ovf[q] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rstat(0, "R1"); check(last_rd == 32'h33333333, "R1 word0", last_rd, 32'h33333333);
    rstat(3, "R1");
    rstat(4, "R1"); check(last_rd == 32'h0, "R1 sec", last_rd, 32'h0);
    rstat(6, "R1"); check(last_rd == 32'hFFFFFFFF, "R1 upper ne", last_rd, 32'hFFFFFFFF);
    rstat(7, "R1");
    cyc(1'b0, 8'h0, 32'h0, 1'b1, {2'd1, 6'd5}, "R1 cfg");

    // R2 configure and read back
    wcfg(0, mkcfg(1, 2, 0, 4) | 32'h0000_1234);
    cyc(1'b0, 8'h0, 32'h0, 1'b1, {2'd1, 6'd0}, "R2");

    // R7 watermark boundaries, R6 packing
    for (int i = 0; i < 2; i++) push(0, 32'hA000 + i, "R3");
    rstat(0, "R7 ne at thr");
    push(0, 32'hA002, "R3");
    rstat(0, "R7 ne above thr");
    for (int i = 3; i < 15; i++) push(0, 32'hA000 + i, "R3");
    rstat(0, "R7 nf at thr");
    push(0, 32'hA00F, "R3");
    rstat(0, "R6 full");
    check(last_rd[3:0] == 4'b1100, "R6 nibble q0", {28'h0, last_rd[3:0]}, 32'hC);

    // R5 overflow
    push(0, 32'hDEAD, "R5");
    rstat(4, "R11"); check(last_rd == 32'h1, "R5 ovf set", last_rd, 32'h1);
    rstat(0, "R5 full kept");
    cyc(1'b1, {2'd2, 6'd4}, 32'h2, 1'b0, 8'h0, "R5");
    rstat(4, "R5 still set");
    cyc(1'b1, {2'd2, 6'd4}, 32'h1, 1'b0, 8'h0, "R5");
    rstat(4, "R5"); check(last_rd == 32'h0, "R5 ovf clear", last_rd, 32'h0);

    // R3 order
    for (int i = 0; i < 16; i++) pop(0, "R3");
    // R4 empty pop
    pop(0, "R4"); check(last_rd == 32'h0, "R4 empty pop", last_rd, 32'h0);
    push(0, 32'h5151, "R4");
    pop(0, "R4"); check(last_rd == 32'h5151, "R4 after empty", last_rd, 32'h5151);

    // R9 simultaneous push and pop
    push(0, 32'h11, "R9"); push(0, 32'h22, "R9");
    cyc(1'b1, {2'd0, 6'd0}, 32'h33, 1'b1, {2'd0, 6'd0}, "R9");
    rstat(0, "R9");
    pop(0, "R9"); pop(0, "R9"); pop(0, "R9");

    // R8 upper queue flags
    wcfg(40, mkcfg(2, 3, 1, 8));
    for (int i = 0; i < 4; i++) push(40, 32'hB000 + i, "R8");
    rstat(6, "R8 ne at thr");
    push(40, 32'hB004, "R8");
    rstat(6, "R8 ne cleared");
    for (int i = 5; i < 32; i++) push(40, 32'hB000 + i, "R8");
    rstat(7, "R8 full"); check(last_rd == 32'h100, "R8 full bit", last_rd, 32'h100);
    push(40, 32'hBAD, "R8");
    for (int i = 0; i < 32; i++) pop(40, "R3");

    // R10 unconfigured queue
    push(3, 32'h777, "R10");
    rstat(0, "R10");
    rstat(4, "R10");
    pop(3, "R10");

    // random phase
    for (int i = 0; i < 8; i++)
      wcfg(qs[i], mkcfg($urandom % 8, $urandom % 8, $urandom % 4, 16 + 8*i));
    for (int n = 0; n < 6000; n++) begin
      bit we, re;
      logic [7:0] wa, ra;
      logic [31:0] wd;
      int sel;
      we = ($urandom % 100) < 60;
      re = ($urandom % 100) < 55;
      wd = $urandom;
      sel = $urandom % 100;
      if (sel < 85)      wa = {2'd0, 6'(qs[$urandom % 8])};
      else if (sel < 90) wa = {2'd0, 6'($urandom % 64)};
      else if (sel < 95) wa = {2'd2, 6'(4 + $urandom % 2)};
      else begin
        int k = $urandom % 8;
        wa = {2'd1, 6'(qs[k])};
        wd = mkcfg($urandom % 8, $urandom % 8, $urandom % 4, 16 + 8*k);
      end
      sel = $urandom % 100;
      if (sel < 70)      ra = {2'd0, 6'(qs[$urandom % 8])};
      else if (sel < 92) ra = {2'd2, 6'($urandom % 8)};
      else               ra = {2'd1, 6'($urandom % 64)};
      cyc(we, wa, wd, re, ra, (ra[7:6] == 2'd0) ? "R3 rnd" : "R6 rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule